// File: doc/BRIEF.md
# CAN Receive Message Buffer

This block holds one receive message buffer for a CAN controller. A frame arrives already decoded: identifier, eight data bytes, data length code and remote-request flag, marked by a one-cycle valid strobe. The block compares the frame identifier with the buffer identifier under an acceptance mask. When the buffer is armed and the frame matches, it latches the frame into a hidden staging register and then copies it into the visible buffer, one word per cycle. During the copy the buffer status shows a busy code.

After the copy the status shows whether the buffer took a frame into an empty slot (full) or replaced a frame that was not yet read (overrun). An interrupt pending flag is raised when the buffer becomes full. A lock option makes the buffer keep its first frame until software rearms it. Software uses a small register port to set the mask and identifier, write the status code, set the enable bits, clear the pending flag and read back the frame.

Software arms the buffer in this order: mask, identifier, then the ready code in the status field. To read a frame it writes the ready code, reads the identifier and payload, and reads the status again. If the status is no longer ready, a newer frame has arrived during the read.

Top module: `can_rx_mailbox`

## Requirements
- R1: After reset the control register reads 0 (status 0000, interrupt enable, lock and pending all 0), the identifier and mask read 0 and `irq` is low.
- R2: Register map, word addressed. 0 is control: bits [3:0] status, bit 4 interrupt enable, bit 5 lock, bit 6 pending (reads the flag; writing 1 clears it). 1 is the identifier in bits [28:0]. 2 is the mask. 3 holds the data length code in bits [3:0] and the remote flag in bit 4. 4+j is data word j, equal to frame data bits [16j+15:16j]. A frame is accepted only when ((frame_id XOR buffer_id) AND mask) is 0.
- R3: An accepted frame makes the status read 0011 (busy) for exactly 5 cycles, starting with the cycle after the clock edge that sampled the strobe. The result status follows in the next cycle.
- R4: A copy into a buffer whose status was 0010 (ready) leaves status 0100 (full). The identifier register then holds the frame identifier, and registers 3 to 7 hold the frame's length code, remote flag and data.
- R5: With lock off, a matching frame that arrives while the status is 0100 or 0101 is accepted and leaves status 0101 (overrun). The buffer contents are replaced by the new frame.
- R6: A frame strobe presented while the status is busy is ignored: contents and result status come from the frame already being copied.
- R7: When the interrupt enable is 1 and a copy leaves the status at 0100, the pending flag and `irq` are set. Only a write of 1 to control bit 6 clears them.
- R8: With lock on, a buffer in status 0100 or 0101 accepts no frame, and its contents and status are unchanged.
- R9: A status write that arrives during busy never leaves busy stuck. A write of 0010 makes the copy end in 0100 even if the buffer held an unread frame. Any other status code written during busy is discarded.
- R10: Outside busy, a status write takes effect on the next cycle. In status 0000 or any code other than 0010, 0100 and 0101, no frame is accepted.
- R11: A mask bit of 0 makes that identifier bit a don't-care. A mask of all zeros accepts every identifier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid | input | 1 | One-cycle strobe: a decoded frame is present |
| frm_id | input | 29 | Frame identifier |
| frm_data | input | 64 | Frame data bytes |
| frm_dlc | input | 4 | Frame data length code |
| frm_rtr | input | 1 | Frame remote-request flag |
| cpu_addr | input | 3 | Register word address |
| cpu_we | input | 1 | Register write strobe |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data, combinational from the address |
| irq | output | 1 | Interrupt pending flag |

## Verification
The assertions check the following on every cycle:
- an accepted frame always enters busy;
- no frame is taken while busy, or while a locked buffer holds a frame;
- the busy status and the copy sequencer agree, and the copy never runs past its word count;
- every completed copy lands in full or overrun;
- the pending flag rises only out of busy into full.

Only the bench scenarios can show the rest:
- that the copied identifier, length code and data words are right;
- that a strobe during busy has no effect on the stored frame;
- that a ready write during the copy turns a would-be overrun into full;
- how masked identifier bits affect acceptance.

// File: rtl/can_rxbuf_pkg.sv
`timescale 1ns/1ps
package can_rxbuf_pkg;

  localparam logic [3:0] ST_OFF   = 4'b0000;
  localparam logic [3:0] ST_READY = 4'b0010;
  localparam logic [3:0] ST_BUSY  = 4'b0011;
  localparam logic [3:0] ST_FULL  = 4'b0100;
  localparam logic [3:0] ST_OVR   = 4'b0101;

  localparam int CTL_IE   = 4;
  localparam int CTL_LOCK = 5;
  localparam int CTL_PEND = 6;

  // buffer holds a frame that has not been rearmed
  function automatic logic holds_frame(input logic [3:0] st);
    return (st == ST_FULL) || (st == ST_OVR);
  endfunction

  // status allows a new frame to enter
  function automatic logic may_take(input logic [3:0] st, input logic lock);
    return (st == ST_READY) || (!lock && holds_frame(st));
  endfunction

  // status reached once the copy completes
  function automatic logic [3:0] copy_result(input logic unread);
    return unread ? ST_OVR : ST_FULL;
  endfunction

endpackage

// File: rtl/rxbuf_filter.sv
`timescale 1ns/1ps
module rxbuf_filter
  import can_rxbuf_pkg::*;
#(
  parameter int ID_W = 29
) (
  input  logic            frm_valid,
  input  logic [ID_W-1:0] frm_id,
  input  logic [ID_W-1:0] own_id,
  input  logic [ID_W-1:0] acc_mask,
  input  logic [3:0]      st,
  input  logic            lock,
  input  logic            busy,
  output logic            hit,
  output logic            accept
);

  function automatic logic masked_eq(input logic [ID_W-1:0] a,
                                     input logic [ID_W-1:0] b,
                                     input logic [ID_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  assign hit    = masked_eq(frm_id, own_id, acc_mask);
  assign accept = frm_valid && !busy && hit && may_take(st, lock);

endmodule

// File: rtl/rxbuf_copier.sv
`timescale 1ns/1ps
module rxbuf_copier #(
  parameter int ID_W   = 29,
  parameter int WORD_W = 16,
  parameter int NDW    = 4,
  localparam int NW    = NDW + 1,
  localparam int IDX_W = $clog2(NW)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic [ID_W-1:0]       frm_id,
  input  logic [NDW*WORD_W-1:0] frm_data,
  input  logic [3:0]            frm_dlc,
  input  logic                  frm_rtr,
  output logic                  busy,
  output logic [IDX_W-1:0]      wr_idx,
  output logic                  wr_last,
  output logic [ID_W-1:0]       stg_id,
  output logic [4:0]            stg_info,
  output logic [WORD_W-1:0]     stg_word
);

  logic [IDX_W-1:0]  cnt;
  logic [WORD_W-1:0] stg_w [NDW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == IDX_W'(NW - 1)) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // hidden staging copy of the frame
  always_ff @(posedge clk) begin
    if (accept) begin
      stg_id   <= frm_id;
      stg_info <= {frm_rtr, frm_dlc};
    end
  end

  for (genvar j = 0; j < NDW; j++) begin : g_stage
    always_ff @(posedge clk) begin
      if (accept) stg_w[j] <= frm_data[j*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    stg_word = '0;
    for (int j = 0; j < NDW; j++) begin
      if (cnt == IDX_W'(j + 1)) stg_word = stg_w[j];
    end
  end

  assign wr_idx  = cnt;
  assign wr_last = busy && (cnt == IDX_W'(NW - 1));

endmodule

// File: rtl/rxbuf_state.sv
`timescale 1ns/1ps
module rxbuf_state
  import can_rxbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       copy_last,
  input  logic       ctl_we,
  input  logic [3:0] wr_st,
  input  logic       wr_ie,
  input  logic       wr_lock,
  input  logic       wr_pclr,
  output logic [3:0] st,
  output logic       ie,
  output logic       lock,
  output logic       pend,
  output logic       full_evt
);

  logic unread;
  logic rearm;
  logic unread_eff;

  assign rearm      = ctl_we && (wr_st == ST_READY);
  assign unread_eff = unread && !rearm;
  assign full_evt   = copy_last && !unread_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_OFF;
      unread <= 1'b0;
    end else if (accept) begin
      st     <= ST_BUSY;
      unread <= holds_frame(st) && !rearm;
    end else if (copy_last) begin
      st     <= copy_result(unread_eff);
      unread <= 1'b0;
    end else if (st == ST_BUSY) begin
      if (rearm) unread <= 1'b0;
    end else if (ctl_we) begin
      st <= wr_st;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie   <= 1'b0;
      lock <= 1'b0;
    end else if (ctl_we) begin
      ie   <= wr_ie;
      lock <= wr_lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend <= 1'b0;
    else if (full_evt && ie)   pend <= 1'b1;
    else if (ctl_we && wr_pclr) pend <= 1'b0;
  end

endmodule

// File: rtl/can_rx_mailbox.sv
`timescale 1ns/1ps
module can_rx_mailbox
  import can_rxbuf_pkg::*;
#(
  parameter int ID_W   = 29,
  parameter int WORD_W = 16,
  parameter int NDW    = 4,
  parameter int CPU_W  = 32,
  localparam int NW     = NDW + 1,
  localparam int IDX_W  = $clog2(NW),
  localparam int DATA_W = NDW * WORD_W,
  localparam int ADDR_W = $clog2(4 + NDW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic [ID_W-1:0]   frm_id,
  input  logic [DATA_W-1:0] frm_data,
  input  logic [3:0]        frm_dlc,
  input  logic              frm_rtr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [CPU_W-1:0]  cpu_wdata,
  output logic [CPU_W-1:0]  cpu_rdata,
  output logic              irq
);

  localparam int A_CTL  = 0;
  localparam int A_ID   = 1;
  localparam int A_MASK = 2;
  localparam int A_INFO = 3;
  localparam int A_DAT0 = 4;

  logic [ID_W-1:0]   buf_id;
  logic [ID_W-1:0]   buf_mask;
  logic [4:0]        buf_info;
  logic [WORD_W-1:0] buf_w [NDW];

  // named internal events
  logic              hit_w;
  logic              accept_w;
  logic              cp_busy;
  logic [IDX_W-1:0]  cp_idx;
  logic              copy_last_w;
  logic [ID_W-1:0]   stg_id;
  logic [4:0]        stg_info;
  logic [WORD_W-1:0] stg_word;
  logic [3:0]        st_q;
  logic              ie_q;
  logic              lock_q;
  logic              pend_q;
  logic              full_evt_w;
  logic              ctl_we;

  assign ctl_we = cpu_we && (cpu_addr == ADDR_W'(A_CTL));

  rxbuf_filter #(.ID_W(ID_W)) u_filter (
    .frm_valid (frm_valid),
    .frm_id    (frm_id),
    .own_id    (buf_id),
    .acc_mask  (buf_mask),
    .st        (st_q),
    .lock      (lock_q),
    .busy      (cp_busy),
    .hit       (hit_w),
    .accept    (accept_w)
  );

  rxbuf_copier #(.ID_W(ID_W), .WORD_W(WORD_W), .NDW(NDW)) u_copier (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept_w),
    .frm_id   (frm_id),
    .frm_data (frm_data),
    .frm_dlc  (frm_dlc),
    .frm_rtr  (frm_rtr),
    .busy     (cp_busy),
    .wr_idx   (cp_idx),
    .wr_last  (copy_last_w),
    .stg_id   (stg_id),
    .stg_info (stg_info),
    .stg_word (stg_word)
  );

  rxbuf_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept_w),
    .copy_last (copy_last_w),
    .ctl_we    (ctl_we),
    .wr_st     (cpu_wdata[3:0]),
    .wr_ie     (cpu_wdata[CTL_IE]),
    .wr_lock   (cpu_wdata[CTL_LOCK]),
    .wr_pclr   (cpu_wdata[CTL_PEND]),
    .st        (st_q),
    .ie        (ie_q),
    .lock      (lock_q),
    .pend      (pend_q),
    .full_evt  (full_evt_w)
  );

  // word 0 of the copy carries identifier and frame info
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_id   <= '0;
      buf_info <= '0;
    end else if (cp_busy && cp_idx == '0) begin
      buf_id   <= stg_id;
      buf_info <= stg_info;
    end else if (cpu_we && cpu_addr == ADDR_W'(A_ID)) begin
      buf_id   <= cpu_wdata[ID_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       buf_mask <= '0;
    else if (cpu_we && cpu_addr == ADDR_W'(A_MASK))   buf_mask <= cpu_wdata[ID_W-1:0];
  end

  for (genvar j = 0; j < NDW; j++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   buf_w[j] <= '0;
      else if (cp_busy && cp_idx == IDX_W'(j + 1))  buf_w[j] <= stg_word;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr == ADDR_W'(A_CTL)) begin
      cpu_rdata[3:0]      = st_q;
      cpu_rdata[CTL_IE]   = ie_q;
      cpu_rdata[CTL_LOCK] = lock_q;
      cpu_rdata[CTL_PEND] = pend_q;
    end else if (cpu_addr == ADDR_W'(A_ID)) begin
      cpu_rdata[ID_W-1:0] = buf_id;
    end else if (cpu_addr == ADDR_W'(A_MASK)) begin
      cpu_rdata[ID_W-1:0] = buf_mask;
    end else if (cpu_addr == ADDR_W'(A_INFO)) begin
      cpu_rdata[4:0] = buf_info;
    end else begin
      for (int j = 0; j < NDW; j++) begin
        if (cpu_addr == ADDR_W'(A_DAT0 + j)) cpu_rdata[WORD_W-1:0] = buf_w[j];
      end
    end
  end

  assign irq = pend_q;

endmodule

// File: rtl/rxbuf_chk.sv
`timescale 1ns/1ps
module rxbuf_chk
  import can_rxbuf_pkg::*;
#(
  parameter int NW = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       busy,
  input logic       copy_last,
  input logic [3:0] st,
  input logic       lock,
  input logic       pend
);

  logic [7:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  // R3
  accept_enters_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (st == ST_BUSY));

  // R6
  no_take_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  // R9
  busy_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSY) == busy);

  // R3
  copy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < 8'(NW)));

  // R4
  copy_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_last |=> (st == ST_FULL || st == ST_OVR));

  // R7
  pend_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> ($past(st) == ST_BUSY && st == ST_FULL));

  // R8
  lock_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && (st == ST_FULL || st == ST_OVR)) |-> !accept);

  // R10
  armed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (st == ST_READY || st == ST_FULL || st == ST_OVR));

endmodule

bind can_rx_mailbox rxbuf_chk #(.NW(NW)) u_rxbuf_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept_w),
  .busy      (cp_busy),
  .copy_last (copy_last_w),
  .st        (st_q),
  .lock      (lock_q),
  .pend      (pend_q)
);

// File: tb/test_can_rx_mailbox.sv
`timescale 1ns/1ps
module test_can_rx_mailbox;

  localparam int ID_W = 29, WORD_W = 16, NDW = 4, NW = NDW + 1, CPU_W = 32, AW = 3;
  localparam logic [3:0] S_OFF = 4'h0, S_RDY = 4'h2, S_BSY = 4'h3, S_FUL = 4'h4, S_OVR = 4'h5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frm_valid = 1'b0;
  logic [ID_W-1:0] frm_id = '0;
  logic [NDW*WORD_W-1:0] frm_data = '0;
  logic [3:0] frm_dlc = '0;
  logic frm_rtr = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_we = 1'b0;
  logic [CPU_W-1:0] cpu_wdata = '0;
  logic [CPU_W-1:0] cpu_rdata;
  logic irq;

  int n_chk = 0, n_fail = 0;

  // model
  logic [3:0] m_st;
  logic m_ie, m_lock, m_pend;
  logic [ID_W-1:0] m_id, m_mask;
  logic [4:0] m_info;
  logic [NDW*WORD_W-1:0] m_data;

  always #2.5 clk = ~clk;

  can_rx_mailbox i_can_rx_mailbox (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
    .frm_data(frm_data), .frm_dlc(frm_dlc), .frm_rtr(frm_rtr),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq(irq)
  );

  function automatic bit b_hit(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b,
                               input logic [ID_W-1:0] m);
    for (int i = 0; i < ID_W; i++) if (m[i] && (a[i] != b[i])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit b_takes(input logic [3:0] s, input logic lk);
    if (s == S_RDY) return 1'b1;
    if ((s == S_FUL || s == S_OVR) && !lk) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] b_ctl();
    return {25'd0, m_pend, m_lock, m_ie, m_st};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(input int a, output logic [31:0] v);
    cpu_addr = AW'(a);
    #1 v = cpu_rdata;
  endtask

  task automatic chk_reg(input int a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    @(negedge clk);
    peek(a, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = AW'(a); cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [3:0] s, input logic ie, input logic lk, input logic clr);
    wr(0, {25'd0, clr, lk, ie, s});
    m_st = s; m_ie = ie; m_lock = lk;
    if (clr) m_pend = 1'b0;
  endtask

  task automatic chk_all(input string req);
    chk_reg(0, b_ctl(), req);
    chk_reg(1, {3'd0, m_id}, req);
    chk_reg(2, {3'd0, m_mask}, req);
    chk_reg(3, {27'd0, m_info}, req);
    for (int j = 0; j < NDW; j++) chk_reg(4 + j, {16'd0, m_data[j*WORD_W +: WORD_W]}, req);
    check(irq == m_pend, req, {31'd0, irq}, {31'd0, m_pend});
  endtask

  // presents one frame, follows busy, updates the model
  task automatic run_frame(input logic [ID_W-1:0] id, input logic [NDW*WORD_W-1:0] d,
                           input logic [3:0] dlc, input logic rtr, input string req);
    logic [31:0] v;
    bit acc;
    logic [3:0] nxt;
    acc = b_hit(id, m_id, m_mask) && b_takes(m_st, m_lock);
    @(negedge clk);
    frm_valid = 1'b1; frm_id = id; frm_data = d; frm_dlc = dlc; frm_rtr = rtr;
    @(negedge clk);
    frm_valid = 1'b0;
    if (acc) begin
      nxt = (m_st == S_RDY) ? S_FUL : S_OVR;
      for (int k = 0; k < NW; k++) begin
        if (k > 0) @(negedge clk);
        peek(0, v);
        check(v[3:0] == S_BSY, "R3 busy span", {28'd0, v[3:0]}, {28'd0, S_BSY});
      end
      @(negedge clk);
      peek(0, v);
      check(v[3:0] == nxt, {req, " result"}, {28'd0, v[3:0]}, {28'd0, nxt});
      if (nxt == S_FUL && m_ie) m_pend = 1'b1;
      m_st = nxt; m_id = id; m_info = {rtr, dlc}; m_data = d;
    end else begin
      peek(0, v);
      check(v[3:0] == m_st, {req, " not taken"}, {28'd0, v[3:0]}, {28'd0, m_st});
      repeat (NW) @(negedge clk);
      peek(0, v);
      check(v[3:0] == m_st, {req, " not taken"}, {28'd0, v[3:0]}, {28'd0, m_st});
    end
  endtask

  function automatic logic [NDW*WORD_W-1:0] rnd_data();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [NDW*WORD_W-1:0] da, db;
    void'($urandom(32'h5eed_c0de));
    m_st = S_OFF; m_ie = 0; m_lock = 0; m_pend = 0;
    m_id = '0; m_mask = '0; m_info = '0; m_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    chk_all("R1 reset");

    // R10 status off: nothing accepted even with a zero mask
    run_frame(29'h1234567, rnd_data(), 4'd8, 1'b0, "R10 off");

    // arm: mask, identifier, ready
    wr(2, 32'h1FFFFF00); m_mask = 29'h1FFFFF00;
    wr(1, 32'h0ABCD000); m_id = 29'h0ABCD000;
    wr_ctl(S_RDY, 1'b1, 1'b0, 1'b0);
    chk_reg(0, b_ctl(), "R10 write ready");

    // R2 mismatch in a compared bit
    run_frame(29'h0ABCE000, rnd_data(), 4'd3, 1'b0, "R2 mismatch");
    // R11 differing don't-care bits, R4 full
    run_frame(29'h0ABCD0A5, 64'h1122_3344_5566_7788, 4'd8, 1'b1, "R4 full");
    chk_all("R4 contents");
    check(irq == 1'b1, "R7 irq set", {31'd0, irq}, 32'd1);

    // R7 clear pending
    wr_ctl(S_FUL, 1'b1, 1'b0, 1'b1);
    chk_all("R7 clear");

    // R5 overrun
    run_frame(29'h0ABCD011, 64'hAAAA_BBBB_CCCC_DDDD, 4'd2, 1'b0, "R5 overrun");
    chk_all("R5 contents");

    // R8 lock keeps first frame
    wr_ctl(S_RDY, 1'b1, 1'b1, 1'b1);
    run_frame(29'h0ABCD022, 64'h0102_0304_0506_0708, 4'd7, 1'b0, "R8 first");
    run_frame(29'h0ABCD033, 64'hFFFF_0000_FFFF_0000, 4'd1, 1'b1, "R8 locked");
    chk_all("R8 contents");

    // R6 strobe during busy ignored
    wr_ctl(S_RDY, 1'b1, 1'b0, 1'b1);
    da = 64'hDEAD_BEEF_0BAD_F00D; db = 64'h5555_6666_7777_8888;
    @(negedge clk);
    frm_valid = 1; frm_id = 29'h0ABCD044; frm_data = da; frm_dlc = 4'd5; frm_rtr = 0;
    @(negedge clk);
    frm_id = 29'h0ABCD055; frm_data = db; frm_dlc = 4'd6;
    @(negedge clk);
    frm_valid = 0;
    repeat (NW + 1) @(negedge clk);
    m_st = S_FUL; m_pend = 1; m_id = 29'h0ABCD044; m_info = 5'd5; m_data = da;
    chk_all("R6 ignored");

    // R9 ready write during busy gives full
    wr_ctl(S_FUL, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    frm_valid = 1; frm_id = 29'h0ABCD066; frm_data = db; frm_dlc = 4'd4; frm_rtr = 1;
    @(negedge clk);
    frm_valid = 0; cpu_we = 1; cpu_addr = 0; cpu_wdata = {25'd0, 3'b001, S_RDY};
    @(negedge clk);
    cpu_we = 0;
    repeat (NW + 1) @(negedge clk);
    m_st = S_FUL; m_pend = 1; m_id = 29'h0ABCD066; m_info = {1'b1, 4'd4}; m_data = db;
    chk_all("R9 ready in busy");

    // R9 other code during busy discarded
    @(negedge clk);
    frm_valid = 1; frm_id = 29'h0ABCD077; frm_data = da; frm_dlc = 4'd0; frm_rtr = 0;
    @(negedge clk);
    frm_valid = 0; cpu_we = 1; cpu_addr = 0; cpu_wdata = {25'd0, 3'b001, S_OFF};
    @(negedge clk);
    cpu_we = 0;
    repeat (NW + 1) @(negedge clk);
    m_st = S_OVR; m_id = 29'h0ABCD077; m_info = 5'd0; m_data = da;
    chk_all("R9 discard in busy");

    // R10 undefined code blocks frames
    wr_ctl(4'h7, 1'b1, 1'b0, 1'b0);
    run_frame(29'h0ABCD088, rnd_data(), 4'd2, 1'b0, "R10 undefined code");

    // random mix
    wr(2, {3'd0, 29'h1FFFFFF0 & 29'($urandom)}); m_mask = 29'h1FFFFFF0 & 29'($urandom);
    wr(2, {3'd0, m_mask});
    wr_ctl(S_RDY, 1'b1, 1'b0, 1'b1);
    for (int it = 0; it < 150; it++) begin
      int r;
      logic [ID_W-1:0] fid;
      r = int'($urandom % 8);
      if (r < 2) begin
        wr_ctl(S_RDY, 1'($urandom), 1'($urandom), 1'b0);
      end else if (r == 2) begin
        wr_ctl(m_st, m_ie, m_lock, 1'b1);
      end else begin
        if ($urandom % 2) fid = (m_id & m_mask) | (29'($urandom) & ~m_mask);
        else fid = 29'($urandom);
        run_frame(fid, rnd_data(), 4'($urandom), 1'($urandom), "R2 R5 R8 random");
      end
      if (it % 10 == 0) chk_all("R4 R7 random readback");
    end
    chk_all("R4 final readback");

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule